// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter

This block sends bytes over a two-wire synchronous link: a serial clock that it generates itself and a data line. Software-side logic writes a byte into a single holding buffer. When the transmitter is enabled, the buffer holds a byte, and the far end signals readiness on an active-low clear-to-send input, the byte moves into a shift register and goes out least significant bit first. Each frame is eight data bits, with no start, stop or parity bits.

The serial clock runs only while a frame is in progress. Its frequency is the core clock divided by (n+1) and then by 2, where n is an 8-bit divisor input. A byte written while another is shifting is taken at the close of the current frame, so the next frame follows with no idle gap. The block has separate flags for an empty buffer and an empty shifter. It also raises a one-cycle interrupt request each time the buffer drains.

Top module: `sync_ser_tx`

## Requirements
- R1: A frame carries exactly 8 bits of the loaded byte on `sdo_o`, least significant bit first. A receiver captures each bit on the rising edge of `sclk_o`.
- R2: Each low half and each high half of `sclk_o` lasts div_i+1 core clock cycles. Rising edges of successive bits are therefore 2·(div_i+1) cycles apart.
- R3: `sdo_o` changes only in the cycle in which `sclk_o` falls. `sclk_o` is 1 out of reset and between frames, and `sdo_o` keeps its last value while idle.
- R4: A frame starts only when `tx_en_i` is 1, the buffer holds a byte (`buf_empty_o` = 0), and either `cts_ni` is 0 or `cts_dis_i` is 1. With `cts_ni` = 1 and `cts_dis_i` = 0, or with `tx_en_i` = 0, a written byte stays in the buffer and `sclk_o` stays high.
- R5: With `cts_dis_i` = 1, the level on `cts_ni` has no effect on starting a frame.
- R6: Once a frame has started, changes to `tx_en_i`, `cts_ni` or the buffer contents do not alter or stop it. All 8 bits of the original byte are sent.
- R7: A byte written before the end of the final high half of the current frame is sent right after it. The next falling edge of `sclk_o` comes div_i+1 cycles after the last rising edge, so 16 bits span 30·(div_i+1) cycles between the first and last rising edges.
- R8: `buf_empty_o` is 1 out of reset. A write (`wr_en_i` = 1) clears it on the next cycle, and moving the byte into the shifter sets it.
- R9: `shift_empty_o` is 1 out of reset. It rises exactly one cycle after the final rising edge of `sclk_o` in a frame, and it falls when a frame starts.
- R10: `irq_o` is a one-cycle pulse, asserted in the same cycle that `buf_empty_o` goes from 0 to 1, with one pulse per such transition.
- R11: If a write coincides with a load of the shifter, the old byte is loaded and the new byte stays in the buffer. `buf_empty_o` stays 0 and no `irq_o` pulse is produced. The new byte is then sent as the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the transmit buffer |
| wr_data_i | input | 8 | Byte to place in the transmit buffer |
| tx_en_i | input | 1 | Transmit enable |
| cts_dis_i | input | 1 | 1 = ignore clear-to-send |
| div_i | input | 8 | Divisor n; half period of the serial clock is n+1 cycles |
| cts_ni | input | 1 | Clear-to-send from the receiver, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data, changes on falling `sclk_o` |
| buf_empty_o | output | 1 | Transmit buffer holds no unsent byte |
| shift_empty_o | output | 1 | Shifter has finished its frame |
| irq_o | output | 1 | One-cycle pulse when the buffer drains |

## Verification
A buffer write and the transfer of the buffer into the shifter can fall in the same core cycle. The bench provokes this by holding a byte in the buffer while clear-to-send is inactive. On one cycle it then lowers `cts_ni` and writes a second byte together. The check requires three things in the next cycle: `buf_empty_o` still at 0 and no `irq_o`. It also requires the wire to carry the first byte and then the second, back to back.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_DIV_W  = 8;
endpackage

// File: rtl/sst_clkdiv.sv
module sst_clkdiv #(
  parameter int unsigned DIV_W = sst_pkg::DEF_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the count bounded if div_i shrinks mid-frame
  assign tick_o = run_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (!run_i || restart_i || tick_o)   cnt_q <= '0;
    else                                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sst_txbuf.sv
module sst_txbuf #(
  parameter int unsigned DATA_W = sst_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] data_q;
  logic              empty_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      // write wins over load: new byte stays, flag stays clear
      if (wr_i) begin
        data_q  <= wdata_i;
        empty_q <= 1'b0;
      end else if (load_i) begin
        empty_q <= 1'b1;
      end
      irq_q <= load_i && !wr_i;
    end
  end

  assign data_o  = data_q;
  assign empty_o = empty_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int unsigned DATA_W = sst_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              active_o,
  output logic              tend_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              empty_o
);
  localparam int unsigned         IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0]    LAST  = IDX_W'(DATA_W - 1);

  logic              active_q, sclk_q, sdo_q, empty_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;

  assign tend_o = active_q && sclk_q && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b1;
      sdo_q    <= 1'b0;
      empty_q  <= 1'b1;
      idx_q    <= '0;
      sh_q     <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      sclk_q   <= 1'b0;
      idx_q    <= '0;
      sh_q     <= data_i;
      sdo_q    <= data_i[0];
      empty_q  <= 1'b0;
    end else begin
      if (tend_o) empty_q <= 1'b1;
      if (tick_i) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else if (idx_q == LAST) begin
          active_q <= 1'b0;
        end else begin
          sclk_q <= 1'b0;
          idx_q  <= idx_q + 1'b1;
          sh_q   <= sh_q >> 1;
          sdo_q  <= sh_q[1];
        end
      end
    end
  end

  assign active_o = active_q;
  assign sclk_o   = sclk_q;
  assign sdo_o    = sdo_q;
  assign empty_o  = empty_q;
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
  parameter int unsigned DATA_W = sst_pkg::DEF_DATA_W,
  parameter int unsigned DIV_W  = sst_pkg::DEF_DIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_en_i,
  input  logic              cts_dis_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cts_ni,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              buf_empty_o,
  output logic              shift_empty_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] buf_data;
  logic buf_empty, active, tend, tick, go_ok, start;

  assign go_ok = tx_en_i && !buf_empty && (cts_dis_i || !cts_ni);
  // idle: start at once; busy: only on the closing tick of the last high half
  assign start = go_ok && (!active || (tend && tick));

  sst_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .wr_i(wr_en_i), .wdata_i(wr_data_i), .load_i(start),
    .data_o(buf_data), .empty_o(buf_empty), .irq_o(irq_o)
  );

  sst_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni,
    .run_i(active), .restart_i(start), .div_i(div_i), .tick_o(tick)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk_i, .rst_ni,
    .start_i(start), .data_i(buf_data), .tick_i(tick),
    .active_o(active), .tend_o(tend),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .empty_o(shift_empty_o)
  );

  assign buf_empty_o = buf_empty;
endmodule

// File: rtl/sync_ser_tx_chk.sv
module sync_ser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic tx_en_i,
  input logic cts_dis_i,
  input logic cts_ni,
  input logic sclk_o,
  input logic sdo_o,
  input logic buf_empty_o,
  input logic shift_empty_o,
  input logic irq_o
);
  AST_SDO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $fell(sclk_o)); // R3

  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_empty_o) |-> $past(tx_en_i) && ($past(cts_dis_i) || !$past(cts_ni))); // R4

  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !buf_empty_o); // R8

  AST_SE_FALL_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shift_empty_o) |-> $fell(sclk_o)); // R9

  AST_IRQ_ON_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $rose(buf_empty_o)); // R10

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R10
endmodule

bind sync_ser_tx sync_ser_tx_chk u_chk (.*);

// File: tb/sync_ser_tx_tb_top.sv
`timescale 1ns/1ps
module sync_ser_tx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, tx_en = 1'b0, cts_dis = 1'b0, cts_n = 1'b1;
  logic [7:0] wr_data = '0, div = '0;
  logic sclk, sdo, buf_empty, shift_empty, irq;

  always #2.5 clk = ~clk;

  sync_ser_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .tx_en_i(tx_en), .cts_dis_i(cts_dis), .div_i(div), .cts_ni(cts_n),
    .sclk_o(sclk), .sdo_o(sdo), .buf_empty_o(buf_empty),
    .shift_empty_o(shift_empty), .irq_o(irq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor
  logic rx_bits [256];
  int   rise_t  [256];
  int   rx_cnt = 0, irq_cnt = 0, se_rise_t = 0, low_run = 0;
  int   mon_checks = 0, mon_fails = 0;
  logic p_sclk = 1'b1, p_sdo = 1'b0, p_se = 1'b1;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sclk = sclk; p_sdo = sdo; p_se = shift_empty; low_run = 0;
    end else begin
      if (sclk && !p_sclk) begin
        rx_bits[rx_cnt % 256] = sdo;
        rise_t[rx_cnt % 256]  = cyc;
        rx_cnt++;
        mon_checks++;
        if (low_run != int'(div) + 1) begin
          mon_fails++;
          $display("FAIL R2 low half actual=%0d expected=%0d", low_run, int'(div) + 1);
        end
      end
      if (sdo !== p_sdo) begin
        mon_checks++;
        if (!(p_sclk && !sclk)) begin
          mon_fails++;
          $display("FAIL R3 sdo moved without falling sclk actual=%0b expected=%0b", sdo, p_sdo);
        end
      end
      if (shift_empty && !p_se) se_rise_t = cyc;
      if (irq) irq_cnt++;
      low_run = sclk ? 0 : low_run + 1;
      p_sclk = sclk; p_sdo = sdo; p_se = shift_empty;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_bits(input int target);
    int t = 0;
    while (rx_cnt < target && t < 8000) begin @(negedge clk); t++; end
    chk(rx_cnt >= target, "R1 bit count (timeout)", rx_cnt, target);
  endtask

  task automatic settle();
    repeat (2 * (int'(div) + 1) + 6) @(negedge clk);
  endtask

  function automatic logic [7:0] got_byte(input int base);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = rx_bits[(base + i) % 256];
    return b;
  endfunction

  // {cts_dis, div, data}; expected result on the wire is data
  localparam int NV = 6;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'd0, 8'hA5}, {1'b1, 8'd1, 8'h3C}, {1'b0, 8'd3, 8'h01},
    {1'b1, 8'd7, 8'h80}, {1'b0, 8'd2, 8'hFF}, {1'b1, 8'd0, 8'h00}
  };

  initial begin
    int base, ic, n;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b1, "R3 reset sclk", sclk, 1);
    chk(buf_empty == 1'b1, "R8 reset buf_empty", buf_empty, 1);
    chk(shift_empty == 1'b1, "R9 reset shift_empty", shift_empty, 1);
    chk(irq == 1'b0, "R10 reset irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    tx_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      cts_dis = VEC[v][16]; div = VEC[v][15:8];
      cts_n = VEC[v][16];   // R5: held inactive when it must be ignored
      n = int'(div);
      base = rx_cnt; ic = irq_cnt;
      write_byte(VEC[v][7:0]);
      chk(buf_empty == 1'b0 || rx_cnt > base || shift_empty == 1'b0, "R8 write clears", buf_empty, 0);
      wait_bits(base + 8);
      settle();
      chk(got_byte(base) == VEC[v][7:0], "R1 byte LSB first", got_byte(base), VEC[v][7:0]);
      chk(rise_t[(base+7)%256] - rise_t[base%256] == 14 * (n + 1), "R2 frame span",
          rise_t[(base+7)%256] - rise_t[base%256], 14 * (n + 1));
      chk(se_rise_t - rise_t[(base+7)%256] == 1, "R9 shift_empty delay",
          se_rise_t - rise_t[(base+7)%256], 1);
      chk(buf_empty == 1'b1, "R8 load sets", buf_empty, 1);
      chk(shift_empty == 1'b1 && sclk == 1'b1, "R3 idle high", sclk, 1);
      chk(irq_cnt == ic + 1, "R10 one irq", irq_cnt - ic, 1);
      chk(rx_cnt == base + 8, "R1 exactly 8 bits", rx_cnt - base, 8);
    end

    // R4: CTS inactive blocks start
    cts_dis = 1'b0; cts_n = 1'b1; div = 8'd1;
    base = rx_cnt;
    write_byte(8'hC3);
    repeat (40) @(negedge clk);
    chk(rx_cnt == base && sclk == 1'b1, "R4 blocked by cts", rx_cnt - base, 0);
    chk(buf_empty == 1'b0, "R4 byte held", buf_empty, 0);
    // R4: enable low blocks start
    tx_en = 1'b0; cts_n = 1'b0;
    repeat (40) @(negedge clk);
    chk(rx_cnt == base && shift_empty == 1'b1, "R4 blocked by enable", rx_cnt - base, 0);
    tx_en = 1'b1;
    wait_bits(base + 8); settle();
    chk(got_byte(base) == 8'hC3, "R4 release sends", got_byte(base), 8'hC3);

    // R6: mid-frame changes ignored
    div = 8'd2; base = rx_cnt;
    write_byte(8'h5A);
    wait_bits(base + 2);
    cts_n = 1'b1; tx_en = 1'b0;
    write_byte(8'h77);
    wait_bits(base + 8); settle();
    chk(got_byte(base) == 8'h5A, "R6 frame completes", got_byte(base), 8'h5A);
    chk(buf_empty == 1'b0, "R6 new byte held", buf_empty, 0);
    repeat (40) @(negedge clk);
    chk(rx_cnt == base + 8, "R6 no extra bits", rx_cnt - base, 8);
    tx_en = 1'b1; cts_n = 1'b0;
    wait_bits(base + 16); settle();
    chk(got_byte(base + 8) == 8'h77, "R6 held byte later", got_byte(base + 8), 8'h77);

    // R7: back-to-back
    div = 8'd1; n = 1; base = rx_cnt;
    write_byte(8'h96);
    wait_bits(base + 1);
    write_byte(8'h4E);
    wait_bits(base + 16); settle();
    chk(got_byte(base) == 8'h96, "R7 first byte", got_byte(base), 8'h96);
    chk(got_byte(base + 8) == 8'h4E, "R7 second byte", got_byte(base + 8), 8'h4E);
    chk(rise_t[(base+15)%256] - rise_t[base%256] == 30 * (n + 1), "R7 no gap",
        rise_t[(base+15)%256] - rise_t[base%256], 30 * (n + 1));

    // R11: write coincides with load
    cts_n = 1'b1; base = rx_cnt;
    write_byte(8'hE1);
    repeat (5) @(negedge clk);
    ic = irq_cnt;
    cts_n = 1'b0; wr_en = 1'b1; wr_data = 8'h2D;
    @(negedge clk); wr_en = 1'b0;
    chk(buf_empty == 1'b0, "R11 buf stays full", buf_empty, 0);
    chk(irq == 1'b0, "R11 no irq", irq, 0);
    wait_bits(base + 16); settle();
    chk(got_byte(base) == 8'hE1, "R11 old byte first", got_byte(base), 8'hE1);
    chk(got_byte(base + 8) == 8'h2D, "R11 new byte next", got_byte(base + 8), 8'h2D);
    chk(irq_cnt == ic + 1, "R11 single irq", irq_cnt - ic, 1);
    chk(rise_t[(base+15)%256] - rise_t[base%256] == 30 * (n + 1), "R7 collision no gap",
        rise_t[(base+15)%256] - rise_t[base%256], 30 * (n + 1));

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, fails + mon_fails + 1);
    $finish;
  end
endmodule